// File: doc/BRIEF.md
# Three-Level Page Table Walker

After a translation-cache miss, this block resolves a virtual address to a physical address. It does this by reading a tree of page tables in memory. The tree has three levels. The caller supplies the virtual address, the kind of access (read, write or execute), the privilege mode of the requester and the frame number of the root table. The walker then reads at most three table entries, one after another, over a memory port that carries one request at a time. It answers with a one-cycle `done_o` pulse. That pulse carries either the physical address and the permission bits of the leaf, or a fault code.

The page size is fixed at elaboration by `PAGE_KB`, which may be 8, 16, 32 or 64. Each table entry is 8 bytes, so one table page holds `PAGE_KB*1024/8` entries. Every level is indexed by a field of `log2(PAGE_KB*1024) - 3` bits. The virtual address therefore holds, from the top down: a run of bits that must copy the most significant bit of the root index, then the root index, the middle index, the leaf index and the byte offset.

Entry layout, as the walker decodes it: bit 0 is valid, bit 1 traps reads, bit 2 traps writes and bit 3 traps instruction fetches. Bits 7:4 are the read enables and bits 11:8 are the write enables, one bit per mode: kernel=0, executive=1, supervisor=2, user=3. Bits above 11 hold the frame number. Access codes are read=0, write=1 and execute=2 (3 also counts as execute). Fault codes are 0 none, 1 access violation, 2 translation not valid, 3 read trap, 4 write trap and 5 fetch trap.

Top module: `ptw_walker`

## Requirements
- R1: A walk that ends without a fault returns `pa_o` = {leaf entry frame number, virtual address offset bits}, with the offset unchanged.
- R2: If any bit of the virtual address above the root index differs from the root index MSB, the walker reports fault 1 at level 0, issues no memory read, and pulses `done_o` in the cycle after the start.
- R3: Reads go to the root, middle and leaf tables in that order. Each read goes to address (table frame << offset width) + index*8. The root frame comes from `root_pfn_i`, and each later frame comes from the entry just read.
- R4: An entry with bit 0 clear, at any level, ends the walk with fault 2. `level_o` names that level (0 root, 1 middle, 2 leaf), and no further reads follow.
- R5: At the leaf, read and execute need the read-enable bit of the current mode, and write needs the write-enable bit. If that bit is missing the result is fault 1 at level 2, and this takes priority over the trap bits.
- R6: When the mode permission holds, a set trap bit that matches the access type gives fault 3 (read), 4 (write) or 5 (execute). Trap bits for other access types have no effect.
- R7: `mem_req_o` stays high, with `mem_addr_o` stable, until `mem_ack_i` is seen. Only one read is outstanding at a time.
- R8: A start request that arrives while a walk is in progress is ignored. It does not alter the result or produce an extra `done_o`.
- R9: `done_o` is a single-cycle pulse. When a valid leaf was reached, `rd_en_o` and `wr_en_o` carry that leaf's four-mode enable bits.
- R10: While reset is low and afterwards until a start, `busy_o`, `mem_req_o` and `done_o` are low. This includes a reset applied in the middle of a walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a walk; taken only while idle |
| va_i | input | VA_W | Virtual address to translate |
| acc_i | input | 2 | Access type: 0 read, 1 write, 2/3 execute |
| mode_i | input | 2 | Privilege mode: 0 kernel, 1 executive, 2 supervisor, 3 user |
| root_pfn_i | input | PFN_W | Frame number of the root table |
| mem_req_o | output | 1 | Table entry read request |
| mem_addr_o | output | PA_W | Byte address of the entry |
| mem_ack_i | input | 1 | Read data valid |
| mem_rdata_i | input | PTE_W | Entry contents |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle result strobe |
| fault_o | output | 3 | Fault code, 0 when translated |
| level_o | output | 2 | Level at which the walk ended |
| pa_o | output | PA_W | Physical address, zero on fault |
| rd_en_o | output | 4 | Leaf read enables per mode |
| wr_en_o | output | 4 | Leaf write enables per mode |

## Verification
A start that fails the sign check sets `done_o` on the first edge after the start is taken. Otherwise each entry read takes two cycles plus the memory's extra wait. That gives 1 + 2·reads cycles with an immediate responder, which is 7 cycles for a full walk and 3, 5 or 7 cycles for an invalid entry at level 0, 1 or 2. The bench drives inputs and samples outputs at falling edges. It counts falling edges from the start to the cycle in which `done_o` is first high, and compares that count with the expected value. It checks in the following cycle that the strobe has dropped. The bench also repeats a walk with a slowed responder to confirm that the latency grows by exactly the wait on each read, and that the address holds still while it waits.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_ACV  = 3'd1,
    FLT_TNV  = 3'd2,
    FLT_TRD  = 3'd3,
    FLT_TWR  = 3'd4,
    FLT_TEX  = 3'd5
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1
  } walk_st_e;

  localparam int unsigned LEVELS    = 3;
  localparam int unsigned ENTRY_LG  = 3;   // 8-byte entries
  localparam int unsigned MODES     = 4;

  // entry bit positions
  localparam int unsigned E_VALID   = 0;
  localparam int unsigned E_TRD     = 1;
  localparam int unsigned E_TWR     = 2;
  localparam int unsigned E_TEX     = 3;
  localparam int unsigned E_RD_LSB  = 4;
  localparam int unsigned E_WR_LSB  = 8;
  localparam int unsigned E_PFN_LSB = 12;

  localparam logic [1:0] ACC_WRITE = 2'd1;

endpackage

// File: rtl/ptw_va_split.sv
module ptw_va_split #(
  parameter int unsigned VA_W   = 64,
  parameter int unsigned OFFS_W = 13,
  localparam int unsigned IDX_W  = OFFS_W - ptw_pkg::ENTRY_LG,
  localparam int unsigned USED_W = OFFS_W + ptw_pkg::LEVELS * IDX_W
) (
  input  logic [VA_W-1:0]                       va_i,
  output logic [ptw_pkg::LEVELS-1:0][IDX_W-1:0] idx_o,
  output logic [OFFS_W-1:0]                     off_o,
  output logic                                  sign_ok_o
);

  // idx_o[0] = root, idx_o[1] = middle, idx_o[2] = leaf
  for (genvar g = 0; g < ptw_pkg::LEVELS; g++) begin : g_idx
    localparam int unsigned LSB = OFFS_W + (ptw_pkg::LEVELS - 1 - g) * IDX_W;
    assign idx_o[g] = va_i[LSB +: IDX_W];
  end

  assign off_o = va_i[OFFS_W-1:0];

  if (VA_W > USED_W) begin : g_upper
    localparam int unsigned UP_W = VA_W - USED_W + 1;
    logic [UP_W-1:0] upper;
    assign upper     = va_i[VA_W-1:USED_W-1];
    assign sign_ok_o = (&upper) | (~|upper);
  end else begin : g_noupper
    assign sign_ok_o = 1'b1;
  end

endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check (
  input  logic [11:1]     attr_i,
  input  logic [1:0]      acc_i,
  input  logic [1:0]      mode_i,
  output ptw_pkg::fault_e fault_o,
  output logic [3:0]      rd_en_o,
  output logic [3:0]      wr_en_o
);
  import ptw_pkg::*;

  logic is_wr, is_ex, is_rd, allowed;

  assign rd_en_o = attr_i[E_RD_LSB +: MODES];
  assign wr_en_o = attr_i[E_WR_LSB +: MODES];

  assign is_wr = (acc_i == ACC_WRITE);
  assign is_ex = acc_i[1];
  assign is_rd = ~is_wr & ~is_ex;

  assign allowed = is_wr ? wr_en_o[mode_i] : rd_en_o[mode_i];

  always_comb begin
    if (!allowed)                   fault_o = FLT_ACV;
    else if (is_rd && attr_i[E_TRD]) fault_o = FLT_TRD;
    else if (is_wr && attr_i[E_TWR]) fault_o = FLT_TWR;
    else if (is_ex && attr_i[E_TEX]) fault_o = FLT_TEX;
    else                            fault_o = FLT_NONE;
  end

endmodule

// File: rtl/ptw_seq.sv
module ptw_seq #(
  parameter int unsigned OFFS_W = 13,
  parameter int unsigned PFN_W  = 32,
  localparam int unsigned IDX_W = OFFS_W - ptw_pkg::ENTRY_LG,
  localparam int unsigned PA_W  = PFN_W + OFFS_W,
  localparam int unsigned PTE_W = ptw_pkg::E_PFN_LSB + PFN_W
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  start_i,
  input  logic                                  sign_ok_i,
  input  logic [ptw_pkg::LEVELS-1:0][IDX_W-1:0] idx_i,
  input  logic [OFFS_W-1:0]                     off_i,
  input  logic [1:0]                            acc_i,
  input  logic [1:0]                            mode_i,
  input  logic [PFN_W-1:0]                      root_pfn_i,
  output logic                                  mem_req_o,
  output logic [PA_W-1:0]                       mem_addr_o,
  input  logic                                  mem_ack_i,
  input  logic [PTE_W-1:0]                      mem_rdata_i,
  input  ptw_pkg::fault_e                       perm_fault_i,
  input  logic [3:0]                            perm_rd_i,
  input  logic [3:0]                            perm_wr_i,
  output logic [1:0]                            acc_o,
  output logic [1:0]                            mode_o,
  output logic                                  busy_o,
  output logic                                  done_o,
  output logic [2:0]                            fault_o,
  output logic [1:0]                            level_o,
  output logic [PA_W-1:0]                       pa_o,
  output logic [3:0]                            rd_en_o,
  output logic [3:0]                            wr_en_o
);
  import ptw_pkg::*;

  localparam logic [1:0] LVL_LEAF = 2'(LEVELS - 1);

  walk_st_e                     st_q, st_d;
  logic [1:0]                   lvl_q, lvl_d;
  logic [PFN_W-1:0]             base_q, base_d;
  logic [LEVELS-1:0][IDX_W-1:0] idx_q;
  logic [OFFS_W-1:0]            off_q;
  logic [1:0]                   acc_q, mode_q;

  logic                         done_d;
  fault_e                       fault_d;
  logic [1:0]                   rlvl_d;
  logic [PA_W-1:0]              pa_d;
  logic [3:0]                   rd_d, wr_d;

  logic                         cap_en, adv_en;
  logic [IDX_W-1:0]             cur_idx;
  logic [PFN_W-1:0]             ent_pfn;
  logic                         ent_valid;

  assign cap_en    = (st_q == ST_IDLE) && start_i;
  assign ent_pfn   = mem_rdata_i[E_PFN_LSB +: PFN_W];
  assign ent_valid = mem_rdata_i[E_VALID];

  always_comb begin
    case (lvl_q)
      2'd0:    cur_idx = idx_q[0];
      2'd1:    cur_idx = idx_q[1];
      default: cur_idx = idx_q[2];
    endcase
  end

  assign mem_req_o  = (st_q == ST_WALK);
  assign mem_addr_o = {base_q, cur_idx, {ENTRY_LG{1'b0}}};
  assign busy_o     = (st_q != ST_IDLE);
  assign acc_o      = acc_q;
  assign mode_o     = mode_q;

  // next-state and result logic
  always_comb begin
    st_d    = st_q;
    lvl_d   = lvl_q;
    base_d  = base_q;
    adv_en  = 1'b0;
    done_d  = 1'b0;
    fault_d = FLT_NONE;
    rlvl_d  = lvl_q;
    pa_d    = '0;
    rd_d    = '0;
    wr_d    = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          if (!sign_ok_i) begin
            done_d  = 1'b1;
            fault_d = FLT_ACV;
            rlvl_d  = 2'd0;
          end else begin
            st_d   = ST_WALK;
            lvl_d  = 2'd0;
            base_d = root_pfn_i;
            adv_en = 1'b1;
          end
        end
      end
      ST_WALK: begin
        if (mem_ack_i) begin
          if (!ent_valid) begin
            st_d    = ST_IDLE;
            done_d  = 1'b1;
            fault_d = FLT_TNV;
            rlvl_d  = lvl_q;
          end else if (lvl_q == LVL_LEAF) begin
            st_d    = ST_IDLE;
            done_d  = 1'b1;
            fault_d = perm_fault_i;
            rlvl_d  = lvl_q;
            rd_d    = perm_rd_i;
            wr_d    = perm_wr_i;
            if (perm_fault_i == FLT_NONE) pa_d = {ent_pfn, off_q};
          end else begin
            lvl_d  = lvl_q + 2'd1;
            base_d = ent_pfn;
            adv_en = 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // control state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      lvl_q  <= '0;
      done_o <= 1'b0;
    end else begin
      st_q   <= st_d;
      lvl_q  <= lvl_d;
      done_o <= done_d;
    end
  end

  // walk context, loaded on an accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      off_q  <= '0;
      acc_q  <= '0;
      mode_q <= '0;
    end else if (cap_en) begin
      idx_q  <= idx_i;
      off_q  <= off_i;
      acc_q  <= acc_i;
      mode_q <= mode_i;
    end
  end

  // current table frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      base_q <= '0;
    else if (adv_en) base_q <= base_d;
  end

  // result registers, loaded with the done strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_o <= '0;
      level_o <= '0;
      pa_o    <= '0;
      rd_en_o <= '0;
      wr_en_o <= '0;
    end else if (done_d) begin
      fault_o <= fault_d;
      level_o <= rlvl_d;
      pa_o    <= pa_d;
      rd_en_o <= rd_d;
      wr_en_o <= wr_d;
    end
  end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int unsigned PAGE_KB = 8,
  parameter int unsigned VA_W    = 64,
  parameter int unsigned PFN_W   = 32,
  localparam int unsigned OFFS_W = $clog2(PAGE_KB) + 10,
  localparam int unsigned IDX_W  = OFFS_W - ptw_pkg::ENTRY_LG,
  localparam int unsigned PA_W   = PFN_W + OFFS_W,
  localparam int unsigned PTE_W  = ptw_pkg::E_PFN_LSB + PFN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [VA_W-1:0]  va_i,
  input  logic [1:0]       acc_i,
  input  logic [1:0]       mode_i,
  input  logic [PFN_W-1:0] root_pfn_i,
  output logic             mem_req_o,
  output logic [PA_W-1:0]  mem_addr_o,
  input  logic             mem_ack_i,
  input  logic [PTE_W-1:0] mem_rdata_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [2:0]       fault_o,
  output logic [1:0]       level_o,
  output logic [PA_W-1:0]  pa_o,
  output logic [3:0]       rd_en_o,
  output logic [3:0]       wr_en_o
);

  logic [ptw_pkg::LEVELS-1:0][IDX_W-1:0] idx;
  logic [OFFS_W-1:0]                     off;
  logic                                  sign_ok;
  ptw_pkg::fault_e                       perm_fault;
  logic [3:0]                            perm_rd, perm_wr;
  logic [1:0]                            acc_q, mode_q;

  ptw_va_split #(
    .VA_W   (VA_W),
    .OFFS_W (OFFS_W)
  ) split_i (
    .va_i      (va_i),
    .idx_o     (idx),
    .off_o     (off),
    .sign_ok_o (sign_ok)
  );

  ptw_perm_check perm_i (
    .attr_i  (mem_rdata_i[11:1]),
    .acc_i   (acc_q),
    .mode_i  (mode_q),
    .fault_o (perm_fault),
    .rd_en_o (perm_rd),
    .wr_en_o (perm_wr)
  );

  ptw_seq #(
    .OFFS_W (OFFS_W),
    .PFN_W  (PFN_W)
  ) seq_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .sign_ok_i    (sign_ok),
    .idx_i        (idx),
    .off_i        (off),
    .acc_i        (acc_i),
    .mode_i       (mode_i),
    .root_pfn_i   (root_pfn_i),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_ack_i    (mem_ack_i),
    .mem_rdata_i  (mem_rdata_i),
    .perm_fault_i (perm_fault),
    .perm_rd_i    (perm_rd),
    .perm_wr_i    (perm_wr),
    .acc_o        (acc_q),
    .mode_o       (mode_q),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .fault_o      (fault_o),
    .level_o      (level_o),
    .pa_o         (pa_o),
    .rd_en_o      (rd_en_o),
    .wr_en_o      (wr_en_o)
  );

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int unsigned VA_W   = 64,
  parameter int unsigned OFFS_W = 13,
  parameter int unsigned PA_W   = 45,
  localparam int unsigned USED_W = OFFS_W + 3 * (OFFS_W - 3)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [VA_W-1:0]   va_i,
  input logic              busy_o,
  input logic              mem_req_o,
  input logic [PA_W-1:0]   mem_addr_o,
  input logic              mem_ack_i,
  input logic              done_o,
  input logic [2:0]        fault_o,
  input logic [1:0]        level_o,
  input logic [OFFS_W-1:0] pa_off
);

  logic              bad_top;
  logic [OFFS_W-1:0] exp_off;

  assign bad_top = va_i[VA_W-1:USED_W-1] != {(VA_W-USED_W+1){va_i[USED_W-1]}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 exp_off <= '0;
    else if (start_i && !busy_o) exp_off <= va_i[OFFS_W-1:0];
  end

  // R10: quiet under reset
  p_rst_quiet_r10: assert property (@(posedge clk)
    !rst_n |-> !mem_req_o && !done_o && !busy_o);

  // R7: request held with a stable address until acknowledged
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));

  // R2: a bad upper field faults at once without a read
  p_sign_acv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o && bad_top |=>
      done_o && fault_o == 3'd1 && level_o == 2'd0 && !mem_req_o);

  // R4: a not-valid result names a real level
  p_tnv_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && fault_o == 3'd2 |-> level_o != 2'd3);

  // R1: offset bits pass through on success
  p_pa_offset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && fault_o == 3'd0 |-> pa_off == exp_off);

  // R9: the strobe appears only with the walker idle
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && !mem_req_o);

endmodule

bind ptw_walker ptw_walker_chk #(
  .VA_W   (VA_W),
  .OFFS_W (OFFS_W),
  .PA_W   (PA_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .va_i       (va_i),
  .busy_o     (busy_o),
  .mem_req_o  (mem_req_o),
  .mem_addr_o (mem_addr_o),
  .mem_ack_i  (mem_ack_i),
  .done_o     (done_o),
  .fault_o    (fault_o),
  .level_o    (level_o),
  .pa_off     (pa_o[OFFS_W-1:0])
);

// File: tb/ptw_walker_tb_top.sv
module ptw_walker_tb_top;

  localparam int OFFS = 13;
  localparam int IDX  = 10;
  localparam int PFN  = 32;
  localparam int PTEW = 12 + PFN;
  localparam int PAW  = PFN + OFFS;
  localparam logic [PFN-1:0] ROOT_PFN = 32'd1;
  localparam logic [PFN-1:0] MID_PFN  = 32'd2;
  localparam logic [PFN-1:0] LEAF_TBL = 32'd3;
  localparam logic [PFN-1:0] DATA_PFN = 32'h0001_2340;

  function automatic logic [11:0] lf(logic v, logic tr, logic tw, logic te,
                                     logic [3:0] rd, logic [3:0] wr);
    return {wr, rd, te, tw, tr, v};
  endfunction

  function automatic logic [63:0] mk(logic [9:0] r, logic [9:0] m, logic [9:0] l,
                                     logic sb, logic [1:0] acc, logic [1:0] md,
                                     logic rv, logic mv, logic [11:0] leaf,
                                     logic [2:0] ef, logic [1:0] el);
    return {10'b0, el, ef, leaf, mv, rv, md, acc, sb, l, m, r};
  endfunction

  localparam int NV = 15;
  localparam logic [63:0] VEC [NV] = '{
    mk(10'd5,   10'd6,  10'd7,  1'b0, 2'd0, 2'd0, 1'b1, 1'b1, lf(1,0,0,0,4'b0001,4'b0000), 3'd0, 2'd2),
    mk(10'd1,   10'd2,  10'd3,  1'b0, 2'd1, 2'd3, 1'b1, 1'b1, lf(1,0,0,0,4'b0000,4'b1000), 3'd0, 2'd2),
    mk(10'd17,  10'd9,  10'd33, 1'b0, 2'd2, 2'd2, 1'b1, 1'b1, lf(1,0,0,0,4'b0100,4'b0000), 3'd0, 2'd2),
    mk(10'd4,   10'd4,  10'd4,  1'b0, 2'd1, 2'd1, 1'b1, 1'b1, lf(1,0,0,0,4'b0010,4'b0000), 3'd1, 2'd2),
    mk(10'd8,   10'd11, 10'd12, 1'b0, 2'd0, 2'd3, 1'b1, 1'b1, lf(1,1,0,0,4'b1000,4'b0000), 3'd3, 2'd2),
    mk(10'd20,  10'd21, 10'd22, 1'b0, 2'd1, 2'd0, 1'b1, 1'b1, lf(1,0,1,0,4'b0000,4'b0001), 3'd4, 2'd2),
    mk(10'd30,  10'd31, 10'd32, 1'b0, 2'd2, 2'd0, 1'b1, 1'b1, lf(1,0,0,1,4'b0001,4'b0000), 3'd5, 2'd2),
    mk(10'd40,  10'd41, 10'd42, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, lf(1,0,0,0,4'b1111,4'b1111), 3'd2, 2'd0),
    mk(10'd50,  10'd51, 10'd52, 1'b0, 2'd0, 2'd0, 1'b1, 1'b0, lf(1,0,0,0,4'b1111,4'b1111), 3'd2, 2'd1),
    mk(10'd60,  10'd61, 10'd62, 1'b0, 2'd0, 2'd0, 1'b1, 1'b1, lf(0,0,0,0,4'b1111,4'b1111), 3'd2, 2'd2),
    mk(10'd70,  10'd71, 10'd72, 1'b1, 2'd0, 2'd0, 1'b1, 1'b1, lf(1,0,0,0,4'b1111,4'b1111), 3'd1, 2'd0),
    mk(10'h2A5, 10'd13, 10'd14, 1'b0, 2'd0, 2'd0, 1'b1, 1'b1, lf(1,0,0,0,4'b0001,4'b0000), 3'd0, 2'd2),
    mk(10'd90,  10'd91, 10'd92, 1'b0, 2'd0, 2'd2, 1'b1, 1'b1, lf(1,0,1,1,4'b0100,4'b0000), 3'd0, 2'd2),
    mk(10'd93,  10'd94, 10'd95, 1'b0, 2'd0, 2'd3, 1'b1, 1'b1, lf(1,1,0,0,4'b0000,4'b1111), 3'd1, 2'd2),
    mk(10'd96,  10'd97, 10'd98, 1'b0, 2'd1, 2'd2, 1'b1, 1'b1, lf(1,0,0,0,4'b0100,4'b0000), 3'd1, 2'd2)
  };

  logic            clk, rst_n, start;
  logic [63:0]     va;
  logic [1:0]      acc, mode;
  logic            req, ack, busy, done;
  logic [PAW-1:0]  addr, pa;
  logic [PTEW-1:0] rdata;
  logic [2:0]      fault;
  logic [1:0]      level;
  logic [3:0]      rd_en, wr_en;

  int tests, fails;
  bit finished;

  ptw_walker dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .va_i(va), .acc_i(acc),
    .mode_i(mode), .root_pfn_i(ROOT_PFN), .mem_req_o(req), .mem_addr_o(addr),
    .mem_ack_i(ack), .mem_rdata_i(rdata), .busy_o(busy), .done_o(done),
    .fault_o(fault), .level_o(level), .pa_o(pa), .rd_en_o(rd_en), .wr_en_o(wr_en)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // table memory and responder
  logic [PTEW-1:0] mem [0:1023];
  logic [PAW-1:0]  rlog [0:255];
  int              nrd, stab_err, cnt, dly;
  logic [PAW-1:0]  hold;

  function automatic int key(logic [PAW-1:0] a);
    return int'({a[14:13], a[10:3]});
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ack <= 1'b0;
      cnt <= 0;
    end else if (req && !ack) begin
      if (cnt == 0) hold <= addr;
      else if (addr != hold) stab_err <= stab_err + 1;
      if (cnt >= dly) begin
        ack   <= 1'b1;
        rdata <= mem[key(addr)];
        cnt   <= 0;
      end else cnt <= cnt + 1;
    end else ack <= 1'b0;
    if (req && ack) begin
      rlog[nrd % 256] <= addr;
      nrd <= nrd + 1;
    end
  end

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] make_va(logic [9:0] r, logic [9:0] m, logic [9:0] l,
                                          logic [12:0] off, logic sb);
    logic [42:0] low;
    logic [63:0] v;
    low = {r, m, l, off};
    v = {{21{low[42]}}, low};
    if (sb) v[50] = ~v[50];
    return v;
  endfunction

  task automatic load(int i);
    logic [63:0] v;
    v = VEC[i];
    mem[key({ROOT_PFN, v[9:0], 3'b0})]   = {MID_PFN, 11'b0, v[35]};
    mem[key({MID_PFN, v[19:10], 3'b0})]  = {LEAF_TBL, 11'b0, v[36]};
    mem[key({LEAF_TBL, v[29:20], 3'b0})] = {DATA_PFN + PFN'(i), v[48:37]};
  endtask

  task automatic go(logic [63:0] a, logic [1:0] ac, logic [1:0] md);
    @(negedge clk);
    va = a; acc = ac; mode = md; start = 1'b1;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      n++;
    end while (!done && n < 300);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n, base, exp_rd;
    string tag;
    logic [63:0] v, a;
    logic [12:0] off;
    tests = 0; fails = 0; finished = 0;
    nrd = 0; stab_err = 0; dly = 0;
    start = 0; va = '0; acc = '0; mode = '0; rst_n = 0;
    for (int k = 0; k < 1024; k++) mem[k] = '0;
    repeat (3) @(negedge clk);
    check(!busy && !req && !done, "R10 reset state", {busy, req, done}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !req && !done, "R10 idle after reset", {busy, req, done}, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      load(i);
      off = 13'h0ABC ^ 13'(i * 37);
      tag = v[30] ? "R2" : (v[51:49] == 3'd2) ? "R4" : (v[51:49] == 3'd1) ? "R5" :
            (v[51:49] >= 3'd3) ? "R6" : "R1";
      base = nrd;
      go(make_va(v[9:0], v[19:10], v[29:20], off, v[30]), v[32:31], v[34:33]);
      wait_done(n);
      exp_rd = v[30] ? 0 : int'(v[53:52]) + 1;
      check(fault == v[51:49], $sformatf("%s v%0d fault", tag, i), fault, v[51:49]);
      check(level == v[53:52], $sformatf("%s v%0d level", tag, i), level, v[53:52]);
      check(n == 1 + 2 * exp_rd, $sformatf("%s v%0d latency", v[30] ? "R2" : "R3", i), n, 1 + 2 * exp_rd);
      check(nrd - base == exp_rd, $sformatf("%s v%0d read count", v[30] ? "R2" : "R3", i), nrd - base, exp_rd);
      for (int k = 0; k < exp_rd; k++) begin
        a = (k == 0) ? {ROOT_PFN, v[9:0], 3'b0} : (k == 1) ? {MID_PFN, v[19:10], 3'b0} : {LEAF_TBL, v[29:20], 3'b0};
        check(rlog[(base + k) % 256] == a[PAW-1:0], $sformatf("R3 v%0d read %0d addr", i, k), rlog[(base + k) % 256], a);
      end
      if (v[51:49] == 3'd0)
        check(pa == {DATA_PFN + PFN'(i), off}, $sformatf("R1 v%0d pa", i), pa, {DATA_PFN + PFN'(i), off});
      if (v[53:52] == 2'd2 && v[51:49] != 3'd2)
        check({rd_en, wr_en} == {v[44:41], v[48:45]}, $sformatf("R9 v%0d enables", i), {rd_en, wr_en}, {v[44:41], v[48:45]});
      @(negedge clk);
      check(!done, $sformatf("R9 v%0d strobe width", i), done, 0);
    end

    // R7: slowed responder
    load(0);
    dly = 3;
    base = nrd;
    v = VEC[0];
    go(make_va(v[9:0], v[19:10], v[29:20], 13'h1234, 1'b0), 2'd0, 2'd0);
    wait_done(n);
    check(n == 1 + 5 * 3, "R7 latency with wait", n, 16);
    check(stab_err == 0, "R7 address stable", stab_err, 0);
    check(fault == 3'd0 && pa == {DATA_PFN, 13'h1234}, "R7 result", pa, {DATA_PFN, 13'h1234});
    dly = 0;

    // R8: start while busy is ignored
    load(1);
    v = VEC[1];
    go(make_va(v[9:0], v[19:10], v[29:20], 13'h0777, 1'b0), 2'd1, 2'd3);
    @(negedge clk); start = 0;
    @(negedge clk);
    va = make_va(10'd5, 10'd5, 10'd5, 13'd0, 1'b1); acc = 2'd0; mode = 2'd0; start = 1;
    @(negedge clk); start = 0;
    n = 3;
    while (!done && n < 300) begin @(negedge clk); n++; end
    check(n == 7, "R8 latency unchanged", n, 7);
    check(fault == 3'd0 && pa == {DATA_PFN + 32'd1, 13'h0777}, "R8 result kept", pa, {DATA_PFN + 32'd1, 13'h0777});
    n = 0;
    repeat (12) begin @(negedge clk); if (done) n++; end
    check(n == 0, "R8 no extra strobe", n, 0);

    // R10: reset during a walk
    go(make_va(v[9:0], v[19:10], v[29:20], 13'h0001, 1'b0), 2'd1, 2'd3);
    repeat (3) @(negedge clk);
    start = 0;
    rst_n = 0;
    @(negedge clk);
    check(!busy && !req && !done, "R10 mid-walk reset", {busy, req, done}, 0);
    rst_n = 1;
    repeat (10) @(negedge clk);
    check(!busy && !req && !done, "R10 stays idle", {busy, req, done}, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule